// File: doc/BRIEF.md
# Programmable Pulse Fault Injector

This block sits in series with one digital signal line and, under run-time control, overwrites that line with a repeating disturbance pulse. It is meant for fault-tolerance experiments: a pulse of programmable length repeats with a programmable period, and while it is active the line is forced low, forced high or inverted. An optional random gate can suppress some pulses. A 16-bit pseudo-random sequence is drawn once per period and compared against a threshold.

A pulse-active flag is exported. Neighbouring injectors on other lines can take it as their own select, so that one pulse source drives several corrupted lines together. A control section holds the period counter, the latched pulse shape and the random gate. It passes a small strobe bundle to a datapath section, which applies the corruption and selects the output.

Top module: `pulse_fault_injector`

## Requirements
- R1: During and directly after reset, `pulseActive` is 0 and `sigOut` equals `sigIn`.
- R2: If `enable` is 1 at a rising edge and no period is running, a period starts at that edge. The pulse (`pulseActive`=1) is active during the first W cycles of every P-cycle period. The period counter runs 0..P-1, and W and P are the latched width and period.
- R3: When W is greater than or equal to P, and both are nonzero, `pulseActive` stays 1 for the whole run.
- R4: A latched width of 0 or a latched period of 0 means no injection: `pulseActive` is 0 and `sigOut` equals `sigIn`.
- R5: While the pulse is active, `faultMode` selects the output. 2'b00 forces 0. 2'b01 forces 1. 2'b10 drives the inverse of `sigIn`. 2'b11 passes `sigIn` unchanged.
- R6: While `pulseActive` is 0, `sigOut` equals `sigIn`.
- R7: `widthCfg` and `periodCfg` are sampled only at a period boundary. This is the edge at which the counter is at P-1, or any edge while no period is running. A change in the middle of a period does not alter that period.
- R8: With `probEn`=1, a period's pulse fires only if the draw, taken at its boundary, is less than or equal to `probThresh`. The draw comes from a 16-bit shift-left register, reset to 16'hACE1, whose new LSB is the XOR of bits 15, 13, 12 and 10. The register advances at every boundary while `enable` is 1. With `probEn`=0 every pulse fires.
- R9: When `enable` is 0 at a rising edge, `pulseActive` is 0 from that edge on. The next enabled edge starts a fresh period at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Injection enable |
| sigIn | input | 1 | Original line value |
| widthCfg | input | CNT_W | Pulse width in cycles |
| periodCfg | input | CNT_W | Repetition period in cycles |
| faultMode | input | 2 | Corruption style while active |
| probEn | input | 1 | Enable random gating of pulses |
| probThresh | input | 16 | Fire when draw <= this value |
| sigOut | output | 1 | Possibly corrupted line |
| pulseActive | output | 1 | Pulse currently applied, for chaining |

## Verification
The assertions assume that `faultMode` and `sigIn` are steady between edges when they are sampled. They also assume that `enable` is low throughout reset. The bench drives every input on the falling clock edge, holds `enable` low whenever `rstN` is low, and changes `sigIn` only just before a mid-cycle sample. No input changes close to a rising edge, so every assertion sees settled port values.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  typedef enum logic [1:0] {
    FM_LOW  = 2'b00,
    FM_HIGH = 2'b01,
    FM_FLIP = 2'b10,
    FM_PASS = 2'b11
  } fault_mode_e;

  typedef struct packed {
    logic        inject;
    fault_mode_e mode;
  } inj_strobe_t;
endpackage

// File: rtl/pfi_lfsr.sv
module pfi_lfsr #(
  parameter int          LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  output logic [LFSR_W-1:0] state
);
  logic feedBit;

  assign feedBit = ^(state & TAP_MASK);

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED;
    else if (advance) state <= {state[LFSR_W-2:0], feedBit};
  end
endmodule

// File: rtl/pfi_ctrl.sv
module pfi_ctrl
  import pfi_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CNT_W-1:0]  widthCfg,
  input  logic [CNT_W-1:0]  periodCfg,
  input  logic [1:0]        faultMode,
  input  logic              probEn,
  input  logic [LFSR_W-1:0] probThresh,
  output inj_strobe_t       strobe
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [LFSR_W-1:0] TAP_MASK = LFSR_W'(16'hB400);

  logic [CNT_W-1:0]  curWidth;
  logic [CNT_W-1:0]  curPeriod;
  logic [CNT_W-1:0]  count;
  logic              fireGate;
  logic              boundary;
  logic              drawHit;
  logic [LFSR_W-1:0] draw;

  pfi_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED), .TAP_MASK(TAP_MASK)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .advance (enable && boundary),
    .state   (draw)
  );

  assign boundary = (curPeriod == '0) || (count == curPeriod - CNT_ONE);
  assign drawHit  = (draw <= probThresh);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      curWidth  <= '0;
      curPeriod <= '0;
      count     <= '0;
      fireGate  <= 1'b0;
    end else if (boundary) begin
      curWidth  <= widthCfg;
      curPeriod <= periodCfg;
      count     <= '0;
      fireGate  <= !probEn || drawHit;
    end else begin
      count <= count + CNT_ONE;
    end
  end

  always_comb begin
    strobe.inject = fireGate && (curWidth != '0) && (curPeriod != '0)
                    && (count < curWidth);
    strobe.mode   = fault_mode_e'(faultMode);
  end
endmodule

// File: rtl/pfi_datapath.sv
module pfi_datapath
  import pfi_pkg::*;
(
  input  logic        sigIn,
  input  inj_strobe_t strobe,
  output logic        sigOut,
  output logic        pulseActive
);
  logic faulted;

  always_comb begin
    unique case (strobe.mode)
      FM_LOW:  faulted = 1'b0;
      FM_HIGH: faulted = 1'b1;
      FM_FLIP: faulted = ~sigIn;
      default: faulted = sigIn;
    endcase
  end

  assign sigOut      = strobe.inject ? faulted : sigIn;
  assign pulseActive = strobe.inject;
endmodule

// File: rtl/pulse_fault_injector.sv
module pulse_fault_injector
  import pfi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sigIn,
  input  logic [CNT_W-1:0] widthCfg,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic [1:0]       faultMode,
  input  logic             probEn,
  input  logic [15:0]      probThresh,
  output logic             sigOut,
  output logic             pulseActive
);
  inj_strobe_t strobe;

  pfi_ctrl #(.CNT_W(CNT_W), .LFSR_W(16), .SEED(16'hACE1)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .widthCfg   (widthCfg),
    .periodCfg  (periodCfg),
    .faultMode  (faultMode),
    .probEn     (probEn),
    .probThresh (probThresh),
    .strobe     (strobe)
  );

  pfi_datapath u_dp (
    .sigIn       (sigIn),
    .strobe      (strobe),
    .sigOut      (sigOut),
    .pulseActive (pulseActive)
  );
endmodule

// File: rtl/pfi_checker.sv
module pfi_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       sigIn,
  input logic [1:0] faultMode,
  input logic       sigOut,
  input logic       pulseActive
);
  // R6: an idle pulse leaves the line untouched
  p_pass_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pulseActive |-> (sigOut == sigIn));

  // R5: corruption styles while the pulse is applied
  p_force_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && faultMode == 2'b00) |-> !sigOut);
  p_force_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && faultMode == 2'b01) |-> sigOut);
  p_invert_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && faultMode == 2'b10) |-> (sigOut != sigIn));
  p_mode_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && faultMode == 2'b11) |-> (sigOut == sigIn));

  // R9: a disabled edge drops the pulse from then on
  p_enable_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pulseActive);

  // R1: the reset edge leaves no pulse behind
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> !pulseActive);
endmodule

bind pulse_fault_injector pfi_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sigIn       (sigIn),
  .faultMode   (faultMode),
  .sigOut      (sigOut),
  .pulseActive (pulseActive)
);

// File: tb/pulse_fault_injector_tb.sv
`timescale 1ns/1ps
module pulse_fault_injector_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sigIn = 1'b0;
  logic [CNT_W-1:0] widthCfg = '0;
  logic [CNT_W-1:0] periodCfg = '0;
  logic [1:0] faultMode = 2'b00;
  logic probEn = 1'b0;
  logic [15:0] probThresh = '0;
  logic sigOut;
  logic pulseActive;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pulse_fault_injector #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sigIn(sigIn),
    .widthCfg(widthCfg), .periodCfg(periodCfg), .faultMode(faultMode),
    .probEn(probEn), .probThresh(probThresh),
    .sigOut(sigOut), .pulseActive(pulseActive)
  );

  // {width, period, mode}
  localparam logic [17:0] VEC [8] = '{
    {8'd2, 8'd5, 2'b00},   // R2
    {8'd3, 8'd4, 2'b01},   // R2
    {8'd1, 8'd3, 2'b10},   // R2
    {8'd4, 8'd4, 2'b10},   // R3
    {8'd7, 8'd3, 2'b01},   // R3
    {8'd0, 8'd4, 2'b01},   // R4
    {8'd3, 8'd0, 2'b00},   // R4
    {8'd2, 8'd6, 2'b11}    // R5
  };

  function automatic logic modelOut(input logic act, input logic [1:0] m, input logic s);
    if (!act) return s;
    case (m)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return ~s;
      default: return s;
    endcase
  endfunction

  function automatic logic [15:0] nextDraw(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic check(input string req, input logic expAct, input logic expOut);
    nChecks++;
    if (pulseActive !== expAct || sigOut !== expOut) begin
      nFails++;
      $display("FAIL %s t=%0t: pulseActive=%b sigOut=%b expected pulseActive=%b sigOut=%b",
               req, $time, pulseActive, sigOut, expAct, expOut);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    sigIn = 1'b1; #1 check("R1", 1'b0, 1'b1);
    sigIn = 1'b0; #1 check("R1", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk); #1 check("R1", 1'b0, 1'b0);

    // R2/R3/R4/R5/R6 vector table
    foreach (VEC[v]) begin
      logic [CNT_W-1:0] w;
      logic [CNT_W-1:0] p;
      logic [1:0] m;
      {w, p, m} = VEC[v];
      idle();
      widthCfg = w; periodCfg = p; faultMode = m; probEn = 1'b0;
      enable = 1'b1;
      for (int i = 0; i < 13; i++) begin
        logic act;
        @(negedge clk);
        sigIn = i[0] ^ i[2];
        act = (w != 0) && (p != 0) && ((i % ((p == 0) ? 1 : p)) < w);
        #1 check(act ? "R2_R5" : "R6_R4", act, modelOut(act, m, sigIn));
      end
    end

    // R7: mid-period width change waits for the boundary
    idle();
    widthCfg = 8'd2; periodCfg = 8'd6; faultMode = 2'b01; sigIn = 1'b0; enable = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic act;
      @(negedge clk);
      act = (i < 6) ? ((i % 6) < 2) : ((i % 6) < 5);
      #1 check("R7", act, act);
      if (i == 3) begin widthCfg = 8'd5; periodCfg = 8'd6; end
    end

    // R9: drop enable mid-pulse, then restart at count 0
    idle();
    widthCfg = 8'd3; periodCfg = 8'd5; faultMode = 2'b01; sigIn = 1'b0; enable = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R9", 1'b1, 1'b1);
    enable = 1'b0;
    @(negedge clk); #1 check("R9", 1'b0, 1'b0);
    enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 check("R9", i < 3, i < 3);
    end

    // R8: random gate with extreme thresholds
    idle();
    widthCfg = 8'd1; periodCfg = 8'd2; faultMode = 2'b01; sigIn = 1'b0;
    probEn = 1'b1; probThresh = 16'h0000; enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 check("R8", 1'b0, 1'b0);
    end
    idle();
    probThresh = 16'hFFFF; enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 check("R8", (i % 2) == 0, (i % 2) == 0);
    end

    // R8: mid threshold against the draw sequence from reset
    @(negedge clk);
    enable = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    begin
      logic [15:0] drawVal = 16'hACE1;
      logic fire = 1'b0;
      widthCfg = 8'd2; periodCfg = 8'd3; probThresh = 16'h8000; enable = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (i % 3 == 0) begin
          fire = (drawVal <= 16'h8000);
          drawVal = nextDraw(drawVal);
        end
        #1 check("R8", fire && (i % 3) < 2, fire && (i % 3) < 2);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule